// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh Scheduling

This block turns single-word host requests into strobe sequences for an asynchronous 1M x 4 dynamic memory whose 20-bit word address is split into a row half and a column half that share ten address pins. A request is a valid/ready handshake carrying a write flag, the word address and four data bits. Read data comes back with a one-cycle valid pulse. Only one request is in flight at a time.

After an access the controller leaves the row open. A later request to the same row goes straight to a column cycle with no new row strobe. A request to another row closes the open row, waits out the precharge time, and opens the new row. Two things override the open page. The first is a refresh interval timer, which by default requests one CAS-before-RAS cycle every 15.6 µs. The second is a guard that closes the row early enough that the row strobe never stays low past its maximum active time.

All delays are parameters given in clock cycles. The state machine counts each of them with one shared down-counter.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: When the row strobe falls for an access, `dram_a` carries the row, which is address bits [19:10]. When the column strobe falls, `dram_a` carries the column, which is bits [9:0]. `dram_a` has held that value for at least one clock before each falling edge.
- R3: For a write, `dram_we_n` is low and `dram_dq_oe` is high with the write data for at least one clock before `dram_cas_n` falls. `dram_oe_n` stays high whenever `dram_we_n` is low.
- R4: For a read, `dram_oe_n` is low while `dram_cas_n` is low. `rd_data` returns the word last written to that address (0 if never written) with a one-cycle `rd_valid` pulse. Reads complete in request order.
- R5: A request whose row matches the open row, accepted while that row is still open, causes no new row-strobe falling edge.
- R6: Before any falling edge of `dram_ras_n`, the row strobe has been high for at least T_RP consecutive clocks.
- R7: In a refresh cycle, `dram_cas_n` falls at least one clock before `dram_ras_n` falls, and `dram_we_n` is high when `dram_ras_n` falls.
- R8: Refresh cycles recur every ref_interval_clks(CLK_MHZ) clocks, within the latency of one access, whether the controller is idle or serving a continuous stream of page hits.
- R9: `dram_ras_n` is never low for more than T_RAS_MAX consecutive clocks. An unbroken stream of page hits is split by a forced close and a reopen of the row.
- R10: `req_ready` is low while a refresh is pending or running. A pending refresh is served ahead of any waiting host request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in upper half |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 4 | Captured read word |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data driven toward memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data returned by memory |

## Verification
The risky overlap is an open-page cycle in which a refresh has just become due, or the row-active guard has just expired, while the host is offering another page hit. Only one of these outcomes may win, and refresh must win. The bench provokes this by streaming back-to-back hits and random traffic long enough for the refresh timer to expire many times mid-stream. It judges each overlap at the pins: every read must still return the scoreboard value, the gaps between refresh events must stay inside the interval window, no row-strobe low run may exceed its limit, and `req_ready` must stay low throughout each refresh.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RSET, S_RCD, S_CSET, S_CAS, S_CP, S_OPEN, S_PRE, S_RFC, S_RFR
  } dpc_state_e;

  // clocks per refresh slot: 16 ms / 1024 = 15.625 us
  function automatic int ref_interval_clks(input int clk_mhz);
    return (clk_mhz * 15625) / 1000;
  endfunction

  // last guard count at which a further page hit may still start
  function automatic int ras_close_at(input int t_ras_max, input int t_cas, input int t_cp);
    return t_ras_max - t_cas - t_cp - 4;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dpc_ref_timer.sv
module dpc_ref_timer #(
  parameter int PERIOD = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pend
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= CW'(PERIOD - 1);
      ref_pend <= 1'b0;
    end else begin
      cnt <= tick ? CW'(PERIOD - 1) : cnt - CW'(1);
      if (tick)         ref_pend <= 1'b1;
      else if (ref_ack) ref_pend <= 1'b0;
    end
  end

  // a new slot must never arrive before the previous refresh ran (R8)
  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && ref_pend));

endmodule

// File: rtl/dpc_ras_guard.sv
module dpc_ras_guard #(
  parameter int T_RAS_MAX = 1000,
  parameter int CLOSE_AT  = 995
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  output logic expire
);
  localparam int CW = $clog2(T_RAS_MAX + 2);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                           low_cnt <= '0;
    else if (ras_n)                       low_cnt <= '0;
    else if (low_cnt != CW'(T_RAS_MAX + 1)) low_cnt <= low_cnt + CW'(1);
  end

  assign expire = (low_cnt >= CW'(CLOSE_AT));

  // count of consecutive low clocks never passes the limit (R9)
  p_ras_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CW'(T_RAS_MAX));

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dpc_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int ROW_W     = 10,
  parameter int DQ_W      = 4,
  parameter int CLK_MHZ   = 100,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 2,
  parameter int T_RFSH    = 3,
  parameter int T_RAS_MAX = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [imax(ROW_W, ADDR_W-ROW_W)-1:0] dram_a,
  output logic [DQ_W-1:0]   dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DQ_W-1:0]   dram_dq_in
);
  localparam int COL_W    = ADDR_W - ROW_W;
  localparam int AW       = imax(ROW_W, COL_W);
  localparam int REF_CLKS = ref_interval_clks(CLK_MHZ);
  localparam int CLOSE_AT = ras_close_at(T_RAS_MAX, T_CAS, T_CP);
  localparam int TMAX     = imax(imax(imax(T_RCD, T_CAS), imax(T_CP, T_RP)), T_RFSH);
  localparam int TW       = $clog2(TMAX + 1);
  localparam int HW       = $clog2(T_RP + 1);

  dpc_state_e        state;
  logic [TW-1:0]     tmr;
  logic              cur_we;
  logic [ADDR_W-1:0] cur_addr;
  logic [DQ_W-1:0]   cur_wdata;
  logic              have_req;

  // named internal events
  logic acc_fire, page_hit, ref_pend, ref_ack, ras_expire, tmr_done, wr_phase;

  assign tmr_done = (tmr == '0);
  assign page_hit = (req_addr[ADDR_W-1 -: ROW_W] == cur_addr[ADDR_W-1 -: ROW_W]);
  assign ref_ack  = (state == S_RFC);
  assign req_ready = !ref_pend &&
                     ((state == S_IDLE) || ((state == S_OPEN) && !ras_expire));
  assign acc_fire = req_valid && req_ready;

  dpc_ref_timer #(.PERIOD(REF_CLKS)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pend(ref_pend)
  );

  dpc_ras_guard #(.T_RAS_MAX(T_RAS_MAX), .CLOSE_AT(CLOSE_AT)) u_guard (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .expire(ras_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_we    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (acc_fire) begin
      cur_we    <= req_we;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tmr      <= '0;
      have_req <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ref_pend)      state <= S_RFC;
          else if (acc_fire) state <= S_RSET;
        end
        S_RSET: begin
          state <= S_RCD;
          tmr   <= TW'(T_RCD - 1);
        end
        S_RCD: begin
          if (tmr_done) state <= S_CSET;
          else          tmr   <= tmr - TW'(1);
        end
        S_CSET: begin
          state <= S_CAS;
          tmr   <= TW'(T_CAS - 1);
        end
        S_CAS: begin
          if (tmr_done) begin
            if (!cur_we) begin
              rd_data  <= dram_dq_in;
              rd_valid <= 1'b1;
            end
            state <= S_CP;
            tmr   <= TW'(T_CP - 1);
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        S_CP: begin
          if (tmr_done) state <= S_OPEN;
          else          tmr   <= tmr - TW'(1);
        end
        S_OPEN: begin
          if (ref_pend || ras_expire) begin
            state <= S_PRE;
            tmr   <= TW'(T_RP - 1);
          end else if (acc_fire) begin
            if (page_hit) begin
              state <= S_CSET;
            end else begin
              have_req <= 1'b1;
              state    <= S_PRE;
              tmr      <= TW'(T_RP - 1);
            end
          end
        end
        S_PRE: begin
          if (tmr_done) begin
            if (ref_pend) state <= S_RFC;
            else if (have_req) begin
              have_req <= 1'b0;
              state    <= S_RSET;
            end else state <= S_IDLE;
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        S_RFC: begin
          state <= S_RFR;
          tmr   <= TW'(T_RFSH - 1);
        end
        S_RFR: begin
          if (tmr_done) begin
            state <= S_PRE;
            tmr   <= TW'(T_RP - 1);
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // strobes decoded from the registered state
  assign wr_phase    = cur_we && ((state == S_CSET) || (state == S_CAS));
  assign dram_ras_n  = !((state == S_RCD) || (state == S_CSET) || (state == S_CAS) ||
                         (state == S_CP) || (state == S_OPEN) || (state == S_RFR));
  assign dram_cas_n  = !((state == S_CAS) || (state == S_RFC) || (state == S_RFR));
  assign dram_we_n   = !wr_phase;
  assign dram_dq_oe  = wr_phase;
  assign dram_dq_out = cur_wdata;
  assign dram_oe_n   = !((state == S_CAS) && !cur_we);
  assign dram_a      = ((state == S_RSET) || (state == S_RCD)) ?
                       AW'(cur_addr[ADDR_W-1 -: ROW_W]) : AW'(cur_addr[COL_W-1:0]);

  // consecutive row-strobe-high clocks, for the precharge check
  logic [HW-1:0] ras_hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                          ras_hi_cnt <= HW'(T_RP);
    else if (!dram_ras_n)                ras_hi_cnt <= '0;
    else if (ras_hi_cnt != HW'(T_RP))    ras_hi_cnt <= ras_hi_cnt + HW'(1);
  end

  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi_cnt >= HW'(T_RP)));

  p_row_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && dram_cas_n) |-> $stable(dram_a));

  p_col_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_a));

  p_early_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && $past(dram_dq_oe) && dram_oe_n));

  p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));

  p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);

  p_oe_we_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n);

endmodule

// File: tb/dram_page_ctrl_tb.sv
module dram_page_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 10;
  localparam int REF_CLKS   = (CLK_MHZ * 15625) / 1000;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2, T_RFSH = 3, T_RAS_MAX = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rd_valid;
  logic [3:0] rd_data;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [9:0] dram_a;
  logic [3:0] dram_dq_out, dram_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_page_ctrl #(.CLK_MHZ(CLK_MHZ), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
                   .T_RP(T_RP), .T_RFSH(T_RFSH), .T_RAS_MAX(T_RAS_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_a(dram_a), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int n_checks = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- memory stub ----------------
  logic [3:0] stub_mem [int];
  logic [9:0] stub_row = '0;
  logic [3:0] stub_rd = '0;
  always @(negedge dram_ras_n) if (dram_cas_n) stub_row = dram_a;
  always @(negedge dram_cas_n) begin
    if (!dram_ras_n) begin
      if (!dram_we_n) stub_mem[{12'd0, stub_row, dram_a}] = dram_dq_out;
      else if (stub_mem.exists({12'd0, stub_row, dram_a})) stub_rd = stub_mem[{12'd0, stub_row, dram_a}];
      else stub_rd = 4'h0;
    end
  end
  assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? stub_rd : 4'h0;

  // ---------------- scoreboard ----------------
  logic [3:0] ref_mem [int];
  logic [3:0] exp_q [$];
  logic [9:0] last_row = '0, last_col = '0;
  logic       last_we = 1'b0;
  logic [3:0] last_wd = '0;

  function automatic logic [3:0] ref_rd(input int k);
    return ref_mem.exists(k) ? ref_mem[k] : 4'h0;
  endfunction

  task automatic do_req(input logic wr, input logic [19:0] addr, input logic [3:0] d);
    req_valid = 1'b1; req_we = wr; req_addr = addr; req_wdata = d;
    while (!req_ready) @(negedge clk);
    last_row = addr[19:10]; last_col = addr[9:0]; last_we = wr; last_wd = d;
    if (wr) ref_mem[{12'd0, addr}] = d;
    else exp_q.push_back(ref_rd({12'd0, addr}));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // ---------------- pin monitor ----------------
  int cyc = 0, n_act = 0, n_cbr = 0, last_cbr = -1;
  int lo_run = 0, hi_run = T_RP;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_dqoe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (p_ras && !dram_ras_n) begin
        if (!dram_cas_n) begin
          check(!p_cas && dram_we_n, "R7 cbr order", {p_cas, dram_we_n}, 2'b01);
          if (last_cbr >= 0)
            check((cyc - last_cbr >= REF_CLKS - 20) && (cyc - last_cbr <= REF_CLKS + 20),
                  "R8 refresh gap", cyc - last_cbr, REF_CLKS);
          last_cbr = cyc;
          n_cbr++;
        end else begin
          n_act++;
          check(hi_run >= T_RP, "R6 precharge", hi_run, T_RP);
          check(dram_a == last_row, "R2 row addr", dram_a, last_row);
        end
      end
      if (!p_ras && dram_ras_n)
        check(lo_run <= T_RAS_MAX, "R9 ras low run", lo_run, T_RAS_MAX);
      if (p_cas && !dram_cas_n && !dram_ras_n) begin
        check(dram_a == last_col, "R2 col addr", dram_a, last_col);
        if (last_we)
          check(!p_we && p_dqoe && dram_oe_n && dram_dq_out == last_wd, "R3 early write",
                {p_we, p_dqoe, dram_oe_n, dram_dq_out}, {3'b011, last_wd});
        else
          check(!dram_oe_n && dram_we_n, "R4 read strobes", {dram_oe_n, dram_we_n}, 2'b01);
      end
      if (!dram_we_n && dram_oe_n == 1'b0)
        check(1'b0, "R3 oe during write", dram_oe_n, 1);
      if (!dram_cas_n && dram_ras_n && req_ready)
        check(1'b0, "R10 ready in refresh", req_ready, 0);
      if (rd_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected rd_valid", 1, 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R4 read data", rd_data, e);
        end
      end
      if (dram_ras_n) begin lo_run = 0; hi_run++; end
      else begin lo_run++; hi_run = 0; end
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_dqoe = dram_dq_oe;
    end
  end

  task automatic wait_cbr();
    int c0;
    c0 = n_cbr;
    while (n_cbr == c0) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int a0;
    logic [19:0] lf;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!dram_dq_oe && !rd_valid, "R1 dq/rd idle", {dram_dq_oe, rd_valid}, 0);
    check(req_ready, "R1 ready", req_ready, 1);

    // R5: page hits in one row after a refresh, well clear of the guard
    wait_cbr();
    a0 = n_act;
    for (int i = 0; i < 3; i++) do_req(1'b1, {10'h155, 10'(i * 37)}, 4'(4'h9 ^ i));
    for (int i = 0; i < 3; i++) do_req(1'b0, {10'h155, 10'(i * 37)}, 4'h0);
    check(n_act - a0 == 1, "R5 page hits one activation", n_act - a0, 1);

    // R6: row miss
    a0 = n_act;
    do_req(1'b1, {10'h2AA, 10'h3FF}, 4'hC);
    do_req(1'b0, {10'h2AA, 10'h3FF}, 4'h0);
    check(n_act - a0 >= 1, "R6 miss reopens row", n_act - a0, 1);

    // R9: long hit stream must be split by forced closes
    wait_cbr();
    a0 = n_act;
    for (int i = 0; i < 20; i++) do_req(i[0], {10'h0F0, 10'(i * 11)}, 4'(i));
    check(n_act - a0 >= 2, "R9 forced reopen", n_act - a0, 2);

    // boundary addresses
    do_req(1'b1, 20'h00000, 4'h5);
    do_req(1'b1, 20'hFFFFF, 4'hA);
    do_req(1'b0, 20'h00000, 4'h0);
    do_req(1'b0, 20'hFFFFF, 4'h0);
    do_req(1'b0, 20'h12345, 4'h0);

    // random traffic over a few rows; refresh lands mid-stream (R8, R10)
    lf = 20'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[18:0], lf[19] ^ lf[16]};
      do_req(lf[3], {8'h3C, lf[5:4], lf[15:6]}, lf[19:16]);
    end

    // idle stretch: refresh cadence with no traffic (R8)
    repeat (4 * REF_CLKS) @(negedge clk);
    check(n_cbr >= 10, "R8 refresh count", n_cbr, 10);

    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule